// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block is a calendar clock that advances once per pulse on a 1 Hz tick input. It keeps seconds, minutes, hours, day of month, month, two-digit year and weekday, all as packed BCD bytes. Software reaches the time, alarm, control, status and interrupt-enable registers through a byte-wide register bus. A write takes effect on the clock edge where the write strobe is high. Read data is registered and appears on the cycle after the read strobe.

Software reads the time by first writing the snapshot-request bit in the control register. The live counters are then copied into shadow registers, and the six time addresses return those copies, so the bytes always belong to the same second. The block compares each new time value with a six-byte alarm time. It keeps sticky event flags for each second, minute, hour and day, and drives one level interrupt. That interrupt combines the alarm flag with the flag of a selectable period, each gated by its own enable.

Top module: `calclk_top`

## Requirements
- R1: After reset the status register (0x0E) reads 0x80, with the power-up flag set and the run flag clear. The control (0x0D) and interrupt-enable (0x0F) registers read 0x00, `irq` is low, and a snapshot shows 00:00:00, day 01, month 01, year 00, with weekday (0x06) reading 0.
- R2: The address map is seconds 0x00, minutes 0x01, hours 0x02, day 0x03, month 0x04, year 0x05, weekday 0x06, alarm seconds to alarm year 0x07 to 0x0C, control 0x0D, status 0x0E, interrupt enable 0x0F. Time and alarm bytes are packed BCD, and writes to 0x00 to 0x06 load the live counters directly.
- R3: Control bit 0 is the run enable. A tick has no effect on the time while that bit is 0.
- R4: Writing control with bit 6 set copies the live seconds through year into shadow registers. Reads of 0x00 to 0x05 return the shadow until the next such write, while weekday reads live. Bit 6 reads back as 0.
- R5: Seconds and minutes roll 59 to 00 and hours roll 23 to 00, each carrying into the next field. On the counted tick, status bit 2 (second), bit 3 (minute), bit 4 (hour) and bit 5 (day) set for the events that occurred.
- R6: Day rolls to 01 after the last day of the month: 30 for months 04, 06, 09 and 11, 31 for the other months, and for February 29 when the BCD year is divisible by 4 and 28 otherwise. Month rolls 12 to 01 with a year carry, and year rolls 99 to 00. Weekday counts 0 to 6 and advances when hours wrap.
- R7: Status bit 1 mirrors the run enable. Writing 1 to any of status bits 2 to 7 clears that flag, and writing 0 leaves it unchanged.
- R8: Status bit 6 sets on a counted tick whose new time equals all six alarm bytes. It never sets while the clock is stopped.
- R9: Interrupt-enable bit 3 gates the alarm flag onto `irq`. The output stays high until the flag is cleared or the enable is removed.
- R10: Interrupt-enable bit 2 gates one periodic flag onto `irq`, chosen by bits [1:0]: 00 second, 01 minute, 10 hour, 11 day.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
A wrong carry or month-length decision shows up only when a snapshot is taken after the tick that crosses the boundary. The time is wrong from that second on, so each rollover is checked one tick after it is set up. A wrong status flag appears on the interrupt in the same cycle that the flag settles, because the output is combinational from the flags. A snapshot fault shows up as bytes that change between reads taken without a new request.

// File: rtl/calclk_pkg.sv
// Shared constants and BCD helpers for the calendar clock.
// Assumes all time fields are packed two-digit BCD bytes.
package calclk_pkg;
    localparam int ADDR_W  = 5;
    localparam int BCD_W   = 8;
    localparam int NFIELD  = 6;   // seconds .. year
    localparam int NEVT    = 4;   // second, minute, hour, day events

    localparam logic [ADDR_W-1:0] A_WDAY = 5'h06;
    localparam logic [ADDR_W-1:0] A_ALM0 = 5'h07;
    localparam logic [ADDR_W-1:0] A_ALMN = 5'h0C;
    localparam logic [ADDR_W-1:0] A_CTRL = 5'h0D;
    localparam logic [ADDR_W-1:0] A_STAT = 5'h0E;
    localparam logic [ADDR_W-1:0] A_IEN  = 5'h0F;

    localparam int CTL_RUN  = 0;
    localparam int CTL_SNAP = 6;

    // Increment a BCD byte by one (caller handles the upper limit).
    function automatic logic [BCD_W-1:0] bcd_inc(input logic [BCD_W-1:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return v + 8'd1;
    endfunction

    // Last valid day (BCD) for a BCD month and BCD year.
    function automatic logic [BCD_W-1:0] last_day(input logic [BCD_W-1:0] mon,
                                                  input logic [BCD_W-1:0] yr);
        logic [6:0] ybin;
        ybin = {3'b000, yr[7:4]} * 7'd10 + {3'b000, yr[3:0]};
        case (mon)
            8'h02:                      return (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction
endpackage

// File: rtl/calclk_counter.sv
// Live time counters: seconds through year plus weekday.
// Advances one second when adv is high; a bus write to a field wins
// over advancing (the top suppresses adv during time writes).
module calclk_counter
    import calclk_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          adv,
    input  logic                          wr_en,
    input  logic [2:0]                    wr_sel,
    input  logic [BCD_W-1:0]              wr_data,
    output logic [NFIELD-1:0][BCD_W-1:0]  time_q,
    output logic [BCD_W-1:0]              wday_q,
    output logic [NFIELD-1:0][BCD_W-1:0]  time_nx,
    output logic [NEVT-1:0]               evt
);
    logic [NFIELD-1:0][BCD_W-1:0] lim, lo;
    logic [2:0]                   wrap_low;   // second, minute, hour wraps
    logic [BCD_W-1:0]             wday_nx;

    // Per-field upper limit and restart value.
    always_comb begin
        lim[0] = 8'h59;
        lim[1] = 8'h59;
        lim[2] = 8'h23;
        lim[3] = last_day(time_q[4], time_q[5]);
        lim[4] = 8'h12;
        lim[5] = 8'h99;
        lo     = '0;
        lo[3]  = 8'h01;
        lo[4]  = 8'h01;
    end

    // Ripple the carry from seconds upward to form the next time.
    always_comb begin
        logic c;
        logic w;
        c        = 1'b1;
        wrap_low = '0;
        for (int i = 0; i < NFIELD; i++) begin
            w = c && (time_q[i] == lim[i]);
            if (!c)     time_nx[i] = time_q[i];
            else if (w) time_nx[i] = lo[i];
            else        time_nx[i] = bcd_inc(time_q[i]);
            if (i < 3) wrap_low[i] = w;
            c = w;
        end
    end

    // Weekday follows the day change (hour wrap).
    always_comb begin
        if (!wrap_low[2])          wday_nx = wday_q;
        else if (wday_q == 8'd6)   wday_nx = '0;
        else                       wday_nx = wday_q + 8'd1;
    end

    // Event pulses for the counted tick.
    assign evt = {adv & wrap_low[2], adv & wrap_low[1], adv & wrap_low[0], adv};

    // Counter registers: reset, bus load, or advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q    <= '0;
            time_q[3] <= 8'h01;
            time_q[4] <= 8'h01;
            wday_q    <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NFIELD; i++)
                if (wr_sel == 3'(i)) time_q[i] <= wr_data;
            if (wr_sel == 3'(NFIELD)) wday_q <= {5'b0, wr_data[2:0]};
        end else if (adv) begin
            time_q <= time_nx;
            wday_q <= wday_nx;
        end
    end

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !wr_en) |=> ($stable(time_q) && $stable(wday_q))); // R3
endmodule

// File: rtl/calclk_alarm.sv
// Alarm time storage and compare against the next time value.
// Assumes compare is only meaningful on a counted tick (adv).
module calclk_alarm
    import calclk_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [2:0]                    wr_sel,
    input  logic [BCD_W-1:0]              wr_data,
    input  logic                          adv,
    input  logic [NFIELD-1:0][BCD_W-1:0]  time_nx,
    output logic [NFIELD-1:0][BCD_W-1:0]  alm_q,
    output logic                          hit
);
    logic [NFIELD-1:0] eq;

    genvar g;
    for (g = 0; g < NFIELD; g++) begin : g_field
        // Field compare for one alarm byte.
        assign eq[g] = (alm_q[g] == time_nx[g]);

        // Alarm byte register.
        always_ff @(posedge clk) begin
            if (!rst_n)                             alm_q[g] <= '0;
            else if (wr_en && wr_sel == 3'(g))      alm_q[g] <= wr_data;
        end
    end

    // Match only on a tick that actually advances the clock.
    assign hit = adv && (&eq);

    AST_ALARM_BYTES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(alm_q)); // R8
endmodule

// File: rtl/calclk_top.sv
// Calendar clock top: register decode, control, snapshot shadow,
// status flags (write-one-to-clear), interrupt gating and readback.
// Assumes tick_1hz is a single-cycle pulse synchronous to clk.
module calclk_top
    import calclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic [4:0]        addr,
    input  logic [7:0]        wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [7:0]        rdata,
    output logic              irq
);
    logic                          wr_time, wr_alm, wr_ctrl, wr_stat, wr_ien;
    logic                          run_q, snap, adv, hit;
    logic [NFIELD-1:0][BCD_W-1:0]  time_q, time_nx, alm_q, shadow_q;
    logic [BCD_W-1:0]              wday_q;
    logic [NEVT-1:0]               evt, evt_q;
    logic                          alm_flag, pwr_flag;
    logic [3:0]                    ien_q;

    // Address decode for writes.
    assign wr_time = wr_en && (addr <= A_WDAY);
    assign wr_alm  = wr_en && (addr >= A_ALM0) && (addr <= A_ALMN);
    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign wr_stat = wr_en && (addr == A_STAT);
    assign wr_ien  = wr_en && (addr == A_IEN);
    assign snap    = wr_ctrl && wdata[CTL_SNAP];
    assign adv     = tick_1hz && run_q && !wr_time;

    calclk_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .adv(adv),
        .wr_en(wr_time), .wr_sel(addr[2:0]), .wr_data(wdata),
        .time_q(time_q), .wday_q(wday_q), .time_nx(time_nx), .evt(evt)
    );

    // Alarm bytes start at 0x07, so the field index is addr[2:0] + 1 (mod 8).
    calclk_alarm u_alm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_alm),
        .wr_sel(addr[2:0] + 3'd1), .wr_data(wdata),
        .adv(adv), .time_nx(time_nx), .alm_q(alm_q), .hit(hit)
    );

    // Run enable and interrupt enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            ien_q <= '0;
        end else begin
            if (wr_ctrl) run_q <= wdata[CTL_RUN];
            if (wr_ien)  ien_q <= wdata[3:0];
        end
    end

    // Shadow copy of the live counters on a snapshot request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q    <= '0;
            shadow_q[3] <= 8'h01;
            shadow_q[4] <= 8'h01;
        end else if (snap) begin
            shadow_q <= time_q;
        end
    end

    // Sticky status flags; a new event wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q    <= '0;
            alm_flag <= 1'b0;
            pwr_flag <= 1'b1;
        end else begin
            for (int i = 0; i < NEVT; i++)
                evt_q[i] <= evt[i] | (evt_q[i] & ~(wr_stat & wdata[2+i]));
            alm_flag <= hit | (alm_flag & ~(wr_stat & wdata[6]));
            pwr_flag <= pwr_flag & ~(wr_stat & wdata[7]);
        end
    end

    // Interrupt: gated alarm flag or gated selected periodic flag.
    assign irq = (alm_flag & ien_q[3]) | (evt_q[ien_q[1:0]] & ien_q[2]);

    // Registered read mux.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            if (addr < 5'(NFIELD))                      rdata <= shadow_q[addr[2:0]];
            else if (addr == A_WDAY)                    rdata <= wday_q;
            else if (addr >= A_ALM0 && addr <= A_ALMN)  rdata <= alm_q[addr[2:0] + 3'd1];
            else if (addr == A_CTRL)                    rdata <= {7'b0, run_q};
            else if (addr == A_STAT)                    rdata <= {pwr_flag, alm_flag, evt_q, run_q, 1'b0};
            else if (addr == A_IEN)                     rdata <= {4'b0, ien_q};
            else                                        rdata <= '0;
        end
    end

    AST_PWRUP_NEVER_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_flag |=> !pwr_flag); // R1
    AST_SNAPSHOT_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> (shadow_q == $past(time_q))); // R4
    AST_ALARM_ONLY_ON_RUN_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_flag) |-> $past(tick_1hz && run_q)); // R8
    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_stat && !wr_ien) |=> irq); // R9
endmodule

// File: tb/sim_calclk_top.sv
// Directed bench for calclk_top: one task per scenario.
module sim_calclk_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    calclk_top u0 (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .addr(addr),
        .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic tick();
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    // Stop, load all fields, restart.
    task automatic set_time(input logic [7:0] s, m, h, d, mo, y, wd);
        wr(5'h0D, 8'h00);
        wr(5'h00, s); wr(5'h01, m); wr(5'h02, h);
        wr(5'h03, d); wr(5'h04, mo); wr(5'h05, y); wr(5'h06, wd);
        wr(5'h0D, 8'h01);
    endtask

    // Snapshot (keeping run) and compare the six shadowed bytes.
    task automatic snap_chk(input string tag, input logic run,
                            input logic [7:0] s, m, h, d, mo, y);
        wr(5'h0D, {1'b0, 1'b1, 5'b0, run});
        rd_chk({tag, " sec"},   5'h00, s);
        rd_chk({tag, " min"},   5'h01, m);
        rd_chk({tag, " hour"},  5'h02, h);
        rd_chk({tag, " day"},   5'h03, d);
        rd_chk({tag, " month"}, 5'h04, mo);
        rd_chk({tag, " year"},  5'h05, y);
    endtask

    task automatic t_reset();
        rd_chk("R1 status", 5'h0E, 8'h80);
        rd_chk("R1 ctrl",   5'h0D, 8'h00);
        rd_chk("R1 ien",    5'h0F, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);
        rd_chk("R1 weekday", 5'h06, 8'h00);
        snap_chk("R1 R2 reset time", 1'b0, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00);
        rd_chk("R4 snap bit reads 0", 5'h0D, 8'h00);
    endtask

    task automatic t_hold();
        tick(); tick(); tick();
        snap_chk("R3 stopped", 1'b0, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00);
        rd_chk("R3 no events", 5'h0E, 8'h80);
    endtask

    task automatic t_pwrup();
        wr(5'h0E, 8'h00);
        rd_chk("R7 zero write keeps", 5'h0E, 8'h80);
        wr(5'h0E, 8'h80);
        rd_chk("R7 power-up cleared", 5'h0E, 8'h00);
    endtask

    task automatic t_simple();
        set_time(8'h09, 8'h15, 8'h10, 8'h05, 8'h07, 8'h21, 8'h02);
        rd_chk("R7 run mirror", 5'h0E, 8'h02);
        tick();
        snap_chk("R5 digit carry", 1'b1, 8'h10, 8'h15, 8'h10, 8'h05, 8'h07, 8'h21);
        rd_chk("R5 second event only", 5'h0E, 8'h06);
    endtask

    task automatic t_rollover();
        wr(5'h0E, 8'hFC);
        set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23, 8'h06);
        tick();
        snap_chk("R6 feb non-leap", 1'b1, 8'h00, 8'h00, 8'h00, 8'h01, 8'h03, 8'h23);
        rd_chk("R6 weekday wrap", 5'h06, 8'h00);
        rd_chk("R5 all events", 5'h0E, 8'h3E);
    endtask

    task automatic t_leap();
        set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24, 8'h01);
        tick();
        snap_chk("R6 feb leap", 1'b1, 8'h00, 8'h00, 8'h00, 8'h29, 8'h02, 8'h24);
        rd_chk("R6 weekday inc", 5'h06, 8'h02);
    endtask

    task automatic t_year();
        set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 8'h03);
        tick();
        snap_chk("R6 year wrap", 1'b1, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00);
        set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h10, 8'h03);
        tick();
        snap_chk("R6 30-day month", 1'b1, 8'h00, 8'h00, 8'h00, 8'h01, 8'h05, 8'h10);
    endtask

    task automatic t_snapshot();
        set_time(8'h10, 8'h00, 8'h08, 8'h12, 8'h03, 8'h30, 8'h05);
        wr(5'h0D, 8'h41);
        tick();
        rd_chk("R4 shadow frozen", 5'h00, 8'h10);
        snap_chk("R4 new snapshot", 1'b1, 8'h11, 8'h00, 8'h08, 8'h12, 8'h03, 8'h30);
    endtask

    task automatic t_w1c();
        wr(5'h0E, 8'hFC);
        rd_chk("R7 all cleared", 5'h0E, 8'h02);
        set_time(8'h20, 8'h00, 8'h08, 8'h12, 8'h03, 8'h30, 8'h05);
        tick();
        rd_chk("R7 second flag set", 5'h0E, 8'h06);
        wr(5'h0E, 8'h04);
        rd_chk("R7 one-bit clear", 5'h0E, 8'h02);
    endtask

    task automatic t_alarm();
        set_time(8'h58, 8'h00, 8'h12, 8'h15, 8'h06, 8'h25, 8'h00);
        wr(5'h07, 8'h00); wr(5'h08, 8'h01); wr(5'h09, 8'h12);
        wr(5'h0A, 8'h15); wr(5'h0B, 8'h06); wr(5'h0C, 8'h25);
        rd_chk("R2 alarm minute readback", 5'h08, 8'h01);
        wr(5'h0F, 8'h08);
        wr(5'h0E, 8'hFC);
        tick();
        check("R8 no early match", {7'b0, irq}, 8'h00);
        tick();
        check("R9 alarm irq", {7'b0, irq}, 8'h01);
        rd_chk("R8 alarm flag", 5'h0E, 8'h4E);
        tick();
        check("R9 irq held", {7'b0, irq}, 8'h01);
        wr(5'h0E, 8'h40);
        check("R9 irq cleared", {7'b0, irq}, 8'h00);
        // Stopped: ticks must not produce a match.
        set_time(8'h58, 8'h00, 8'h12, 8'h15, 8'h06, 8'h25, 8'h00);
        wr(5'h07, 8'h59); wr(5'h08, 8'h00);
        wr(5'h0D, 8'h00);
        tick(); tick();
        rd_chk("R8 no match stopped", 5'h0E, 8'h0C);
        check("R8 irq low stopped", {7'b0, irq}, 8'h00);
        wr(5'h0F, 8'h00);
    endtask

    task automatic t_periodic();
        wr(5'h0E, 8'hFC);
        set_time(8'h30, 8'h05, 8'h08, 8'h12, 8'h03, 8'h30, 8'h05);
        wr(5'h0F, 8'h05);
        rd_chk("R10 ien readback", 5'h0F, 8'h05);
        tick();
        check("R10 minute sel no irq", {7'b0, irq}, 8'h00);
        set_time(8'h59, 8'h05, 8'h08, 8'h12, 8'h03, 8'h30, 8'h05);
        tick();
        check("R10 minute sel irq", {7'b0, irq}, 8'h01);
        wr(5'h0E, 8'h08);
        check("R10 minute cleared", {7'b0, irq}, 8'h00);
        wr(5'h0F, 8'h04);
        check("R10 second sel irq", {7'b0, irq}, 8'h01);
        wr(5'h0F, 8'h06);
        check("R10 hour sel no irq", {7'b0, irq}, 8'h00);
        wr(5'h0F, 8'h02);
        check("R10 timer disabled", {7'b0, irq}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_hold();
        t_pwrup();
        t_simple();
        t_rollover();
        t_leap();
        t_year();
        t_snapshot();
        t_w1c();
        t_alarm();
        t_periodic();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule